// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block is the control spine of a four-register in-order pipeline (fetch to decode, decode to execute, execute to memory, memory to writeback). It carries a valid bit, a PC and an exception code for every in-flight instruction, and it also carries the register-write and memory-write enables that decode produces. An exception raised in any stage is not acted on at once. The code is attached to the instruction and travels with it until the instruction reaches the memory stage. The decision to take an exception is made only at that single commit point. As a result, the oldest excepting instruction is always the one taken.

When an exception is taken, the block does several things in the same cycle. It suppresses the memory write of the excepting instruction. It drops that instruction before writeback, and it invalidates every younger instruction. It drives a redirect to a fixed handler address. At the clock edge that ends the cycle, it records the resume PC and the cause. An instruction that is already in writeback is older than the excepting one, so it completes with its register write intact. The datapath, the handler software and the saving of registers belong to other blocks.

Top module: `exc_commit_ctrl`

## Requirements
- R1: While reset is low, every stage valid, wb_reg_we, mem_wr_en and redirect read 0, and saved_pc and saved_cause read 0.
- R2: With no exception taken, an instruction accepted on fe_valid appears on the decode, execute, memory and writeback outputs on the 1st, 2nd, 3rd and 4th following clock edges, always with its own PC. Its write enables are taken from dec_reg_we and dec_mem_we in the cycle it is in decode.
- R3: An exception code of 0 means no exception. An instruction keeps the first nonzero code raised for it, in the order fetch, decode, execute, memory. A code offered to a later stage is ignored once a code is held.
- R4: An exception is taken only in a cycle where mem_valid is 1 and either the code carried to the memory stage or mem_exc is nonzero. A code held in decode or execute never causes a take.
- R5: In the cycle an exception is taken, redirect is 1 and redirect_pc equals the HANDLER_PC parameter. In every other cycle, redirect is 0.
- R6: At the clock edge that ends a take cycle, saved_pc becomes the memory-stage PC and saved_cause becomes the code of that instruction. The carried code wins over mem_exc. At every other edge, both registers hold their value.
- R7: mem_wr_en equals mem_valid AND the instruction's memory-write enable, and it is forced to 0 in a take cycle. The excepting instruction never appears in writeback.
- R8: After a take, the decode, execute and memory stages are all invalid at the next edge. A fetch offered in the take cycle is discarded.
- R9: An instruction in writeback during a take cycle keeps wb_valid and its wb_reg_we. Outside reset, wb_reg_we equals wb_valid AND the instruction's register-write enable.
- R10: An older instruction's exception at the commit point is taken even when a younger instruction raised its own code in an earlier cycle. The younger code is then discarded with its instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_valid | input | 1 | Fetch offers an instruction |
| fe_pc | input | PC_W | PC of the fetched instruction |
| fe_exc | input | CODE_W | Fetch exception code (0 = none) |
| dec_reg_we | input | 1 | Register-write enable for the instruction in decode |
| dec_mem_we | input | 1 | Memory-write enable for the instruction in decode |
| dec_exc | input | CODE_W | Decode exception code for the instruction in decode |
| ex_exc | input | CODE_W | Execute exception code for the instruction in execute |
| mem_exc | input | CODE_W | Memory exception code for the instruction in memory |
| id_valid | output | 1 | Decode stage holds a live instruction |
| id_pc | output | PC_W | Decode stage PC |
| ex_valid | output | 1 | Execute stage holds a live instruction |
| ex_pc | output | PC_W | Execute stage PC |
| mem_valid | output | 1 | Memory stage holds a live instruction |
| mem_pc | output | PC_W | Memory stage PC |
| mem_wr_en | output | 1 | Gated memory write strobe |
| wb_valid | output | 1 | Writeback stage holds a live instruction |
| wb_pc | output | PC_W | Writeback stage PC |
| wb_reg_we | output | 1 | Gated register-file write strobe |
| redirect | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | PC_W | Handler address |
| saved_pc | output | PC_W | Resume PC of the last taken exception |
| saved_cause | output | CODE_W | Cause of the last taken exception |

## Verification
The bench first runs a plain stream with mixed write enables and no exceptions. This shows that PCs and enables are carried correctly when no flush happens. Directed cases then cover three separate things:
- a lone memory-stage fault, which shows the redirect, the capture and the write gating;
- an instruction that collects codes in fetch, decode and memory, which shows that the first code is kept;
- an older memory fault behind a younger decode fault, which shows that priority follows program order and not the time the code was raised.

A long stretch of random traffic with sparse codes in every stage follows. It mixes back-to-back takes, bubbles, and takes that fall while an older instruction is writing back.

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl #(
  parameter int PC_W = 32,
  parameter int CODE_W = 4,
  parameter logic [PC_W-1:0] HANDLER_PC = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fe_valid,
  input  logic [PC_W-1:0]   fe_pc,
  input  logic [CODE_W-1:0] fe_exc,
  input  logic              dec_reg_we,
  input  logic              dec_mem_we,
  input  logic [CODE_W-1:0] dec_exc,
  input  logic [CODE_W-1:0] ex_exc,
  input  logic [CODE_W-1:0] mem_exc,
  output logic              id_valid,
  output logic [PC_W-1:0]   id_pc,
  output logic              ex_valid,
  output logic [PC_W-1:0]   ex_pc,
  output logic              mem_valid,
  output logic [PC_W-1:0]   mem_pc,
  output logic              mem_wr_en,
  output logic              wb_valid,
  output logic [PC_W-1:0]   wb_pc,
  output logic              wb_reg_we,
  output logic              redirect,
  output logic [PC_W-1:0]   redirect_pc,
  output logic [PC_W-1:0]   saved_pc,
  output logic [CODE_W-1:0] saved_cause
);
  localparam logic [CODE_W-1:0] NONE = '0;

  logic              d_v, e_v, m_v, w_v;
  logic [PC_W-1:0]   d_pc, e_pc, m_pc, w_pc;
  logic [CODE_W-1:0] d_code, e_code, m_code;
  logic              e_rwe, e_mwe, m_rwe, m_mwe, w_rwe;
  logic [PC_W-1:0]   epc_q;
  logic [CODE_W-1:0] cause_q;
  logic              take;
  logic [CODE_W-1:0] take_code;

  assign take      = m_v && (m_code != NONE || mem_exc != NONE);
  assign take_code = (m_code != NONE) ? m_code : mem_exc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_v <= 1'b0; e_v <= 1'b0; m_v <= 1'b0; w_v <= 1'b0;
      d_pc <= '0; e_pc <= '0; m_pc <= '0; w_pc <= '0;
      d_code <= NONE; e_code <= NONE; m_code <= NONE;
      e_rwe <= 1'b0; e_mwe <= 1'b0; m_rwe <= 1'b0; m_mwe <= 1'b0; w_rwe <= 1'b0;
      epc_q <= '0; cause_q <= NONE;
    end else begin
      d_v    <= fe_valid & ~take;
      d_pc   <= fe_pc;
      d_code <= fe_exc;

      e_v    <= d_v & ~take;
      e_pc   <= d_pc;
      e_code <= (d_code != NONE) ? d_code : dec_exc;
      e_rwe  <= dec_reg_we;
      e_mwe  <= dec_mem_we;

      m_v    <= e_v & ~take;
      m_pc   <= e_pc;
      m_code <= (e_code != NONE) ? e_code : ex_exc;
      m_rwe  <= e_rwe;
      m_mwe  <= e_mwe;

      w_v    <= m_v & ~take;
      w_pc   <= m_pc;
      w_rwe  <= m_rwe;

      if (take) begin
        epc_q   <= m_pc;
        cause_q <= take_code;
      end
    end
  end

  assign id_valid    = d_v;
  assign id_pc       = d_pc;
  assign ex_valid    = e_v;
  assign ex_pc       = e_pc;
  assign mem_valid   = m_v;
  assign mem_pc      = m_pc;
  assign mem_wr_en   = m_v & m_mwe & ~take;
  assign wb_valid    = w_v;
  assign wb_pc       = w_pc;
  assign wb_reg_we   = w_v & w_rwe;
  assign redirect    = take;
  assign redirect_pc = HANDLER_PC;
  assign saved_pc    = epc_q;
  assign saved_cause = cause_q;

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !id_valid && !ex_valid && !mem_valid);

  // R7
  no_excepting_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !wb_valid);

  // R6
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> saved_pc == $past(mem_pc));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> $stable(saved_pc) && $stable(saved_cause));

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect && ex_valid) |=> mem_valid && mem_pc == $past(ex_pc));

  // R4
  commit_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> mem_valid);

  // R7
  no_write_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !mem_wr_en);

  // R9
  wb_from_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_reg_we |-> $past(mem_valid));
endmodule

// File: tb/exc_commit_ctrl_tb_top.sv
module exc_commit_ctrl_tb_top;
  localparam logic [31:0] HVEC = 32'h0000_0800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic fe_valid = 0, dec_reg_we = 0, dec_mem_we = 0;
  logic [31:0] fe_pc = '0;
  logic [3:0] fe_exc = '0, dec_exc = '0, ex_exc = '0, mem_exc = '0;
  logic id_valid, ex_valid, mem_valid, mem_wr_en, wb_valid, wb_reg_we, redirect;
  logic [31:0] id_pc, ex_pc, mem_pc, wb_pc, redirect_pc, saved_pc;
  logic [3:0] saved_cause;

  exc_commit_ctrl #(.PC_W(32), .CODE_W(4), .HANDLER_PC(HVEC)) dut_i (
    .clk(clk), .rst_n(rst_n), .fe_valid(fe_valid), .fe_pc(fe_pc), .fe_exc(fe_exc),
    .dec_reg_we(dec_reg_we), .dec_mem_we(dec_mem_we), .dec_exc(dec_exc),
    .ex_exc(ex_exc), .mem_exc(mem_exc), .id_valid(id_valid), .id_pc(id_pc),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .mem_valid(mem_valid), .mem_pc(mem_pc),
    .mem_wr_en(mem_wr_en), .wb_valid(wb_valid), .wb_pc(wb_pc), .wb_reg_we(wb_reg_we),
    .redirect(redirect), .redirect_pc(redirect_pc), .saved_pc(saved_pc),
    .saved_cause(saved_cause));

  typedef struct {
    logic [31:0] pc;
    logic [3:0]  code;
    bit rwe, mwe;
    int stg;
  } rec_t;
  rec_t q[$];
  logic [31:0] m_epc = '0;
  logic [3:0]  m_cause = '0;
  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input string nm,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  function automatic int find(input int s);
    foreach (q[i]) if (q[i].stg == s) return i;
    return -1;
  endfunction

  function automatic bit model_take();
    int m = find(3);
    return m >= 0 && (q[m].code != 0 || mem_exc != 0);
  endfunction

  task automatic compare();
    int d = find(1), e = find(2), m = find(3), w = find(4);
    bit tk = model_take();
    bit emw = (m >= 0) && q[m].mwe && !tk;
    chk(id_valid == (d >= 0), "R2/R8", "id_valid", 32'(id_valid), 32'(d >= 0));
    if (d >= 0) chk(id_pc == q[d].pc, "R2", "id_pc", id_pc, q[d].pc);
    chk(ex_valid == (e >= 0), "R2/R8", "ex_valid", 32'(ex_valid), 32'(e >= 0));
    if (e >= 0) chk(ex_pc == q[e].pc, "R2", "ex_pc", ex_pc, q[e].pc);
    chk(mem_valid == (m >= 0), "R2/R8", "mem_valid", 32'(mem_valid), 32'(m >= 0));
    if (m >= 0) chk(mem_pc == q[m].pc, "R2", "mem_pc", mem_pc, q[m].pc);
    chk(mem_wr_en == emw, "R7", "mem_wr_en", 32'(mem_wr_en), 32'(emw));
    chk(wb_valid == (w >= 0), "R2/R7", "wb_valid", 32'(wb_valid), 32'(w >= 0));
    if (w >= 0) begin
      chk(wb_pc == q[w].pc, "R2", "wb_pc", wb_pc, q[w].pc);
      chk(wb_reg_we == q[w].rwe, "R9", "wb_reg_we", 32'(wb_reg_we), 32'(q[w].rwe));
    end else chk(wb_reg_we == 0, "R9", "wb_reg_we", 32'(wb_reg_we), 0);
    chk(redirect == tk, "R4/R5", "redirect", 32'(redirect), 32'(tk));
    if (tk) chk(redirect_pc == HVEC, "R5", "redirect_pc", redirect_pc, HVEC);
    chk(saved_pc == m_epc, "R6", "saved_pc", saved_pc, m_epc);
    chk(saved_cause == m_cause, "R3/R6", "saved_cause", 32'(saved_cause), 32'(m_cause));
  endtask

  task automatic advance();
    int m = find(3);
    if (model_take()) begin
      m_epc = q[m].pc;
      m_cause = (q[m].code != 0) ? q[m].code : mem_exc;
      q.delete();
      return;
    end
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].stg == 1) begin
        q[i].rwe = dec_reg_we;
        q[i].mwe = dec_mem_we;
        if (q[i].code == 0) q[i].code = dec_exc;
      end else if (q[i].stg == 2 && q[i].code == 0) q[i].code = ex_exc;
      q[i].stg++;
    end
    while (q.size() > 0 && q[0].stg == 5) void'(q.pop_front());
    if (fe_valid) q.push_back('{pc: fe_pc, code: fe_exc, rwe: 0, mwe: 0, stg: 1});
  endtask

  task automatic cyc(input bit fv, input logic [31:0] pc, input logic [3:0] fx,
                     input bit rwe, input bit mwe, input logic [3:0] dx,
                     input logic [3:0] ex, input logic [3:0] mx);
    @(negedge clk);
    fe_valid = fv; fe_pc = pc; fe_exc = fx; dec_reg_we = rwe; dec_mem_we = mwe;
    dec_exc = dx; ex_exc = ex; mem_exc = mx;
    #1;
    compare();
    advance();
  endtask

  initial begin
    #50000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      fe_valid = 1; fe_pc = 32'h44; #1;
      chk(!id_valid && !ex_valid && !mem_valid && !wb_valid, "R1", "valids",
          {id_valid, ex_valid, mem_valid, wb_valid}, 0);
      chk(!wb_reg_we && !mem_wr_en && !redirect, "R1", "strobes",
          {wb_reg_we, mem_wr_en, redirect}, 0);
      chk(saved_pc == 0 && saved_cause == 0, "R1", "saved", saved_pc, 0);
    end
    fe_valid = 0;
    @(negedge clk); rst_n = 1;

    // R2: plain stream, mixed enables
    for (int i = 0; i < 8; i++)
      cyc(1, 32'h1000 + 4 * i, 0, i[0], i[1], 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);

    // R4 R5 R6 R7 R9: lone memory fault, older instruction in writeback
    cyc(1, 32'h2000, 0, 0, 0, 0, 0, 0);
    cyc(1, 32'h2004, 0, 1, 0, 0, 0, 0);
    cyc(1, 32'h2008, 0, 1, 1, 0, 0, 0);
    cyc(1, 32'h200c, 0, 0, 1, 0, 0, 0);
    cyc(1, 32'h2010, 0, 0, 0, 0, 0, 0);
    cyc(1, 32'h2014, 0, 0, 0, 0, 0, 7);
    cyc(1, HVEC, 0, 0, 0, 0, 0, 0);
    chk(saved_pc == 32'h2008 && saved_cause == 7, "R6", "lone fault capture",
        saved_pc, 32'h2008);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);

    // R3: first code kept (fetch 2, decode 9, memory 12 offered)
    cyc(1, 32'h3000, 2, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 9, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 4, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 12);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk(saved_cause == 2, "R3", "first code", 32'(saved_cause), 2);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);

    // R10: younger decode fault raised before older memory fault
    cyc(1, 32'h4000, 0, 0, 0, 0, 0, 0);
    cyc(1, 32'h4004, 0, 0, 0, 0, 0, 0);
    cyc(1, 32'h4008, 0, 0, 0, 3, 0, 0);
    cyc(1, 32'h400c, 0, 0, 0, 0, 0, 5);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk(saved_pc == 32'h4000, "R10", "older taken pc", saved_pc, 32'h4000);
    chk(saved_cause == 5, "R10", "older taken cause", 32'(saved_cause), 5);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk(saved_pc == 32'h4000, "R10", "younger discarded", saved_pc, 32'h4000);

    // R8: random traffic with sparse codes
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a = (($urandom % 20) == 0) ? 4'($urandom % 15 + 1) : 4'd0;
      logic [3:0] b = (($urandom % 20) == 0) ? 4'($urandom % 15 + 1) : 4'd0;
      logic [3:0] c = (($urandom % 20) == 0) ? 4'($urandom % 15 + 1) : 4'd0;
      logic [3:0] d = (($urandom % 25) == 0) ? 4'($urandom % 15 + 1) : 4'd0;
      cyc(($urandom % 4) != 0, $urandom & 32'hffff_fffc, a, $urandom % 2,
          $urandom % 2, b, c, d);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule